// File: doc/BRIEF.md
# Distributed Number-Compare Bus Arbiter

This block decides which of several bus masters holds the next bus tenure. There is no central priority encoder. Every master has a local slice that owns a fixed, distinct arbitration number. When a contest starts, each requesting slice drives its number onto a shared set of arbitration lines, modelled as a wired-OR. The lines are resolved one bit per cycle, starting at the most significant bit. A slice drops out of the contest when its own bit is 0 and the lines show 1 at that position. After that it drives nothing. When the last bit has been resolved, only the slice with the largest number is still driving, and it becomes the pending winner.

Arbitration runs at the same time as the current transfer. The master that holds the tenure keeps its grant until it pulses the tenure release input. The pending winner waits in a hold state until that release, and the grant then moves to it at the same edge. A one-hot grant vector and a busy flag report who owns the bus.

The controller is a three-state machine:

- IDLE: no contest is running.
- SETTLE: one bit of the lines is resolved per cycle.
- HOLD: a winner is latched and waits for the bus.

Its transitions are:

- start: IDLE to SETTLE, taken when some master other than the owner requests.
- step: SETTLE to SETTLE, taken while bits remain.
- resolve: SETTLE to HOLD, taken after the least significant bit.
- wait: HOLD to HOLD, taken while an owner still holds the bus.
- handover: HOLD to IDLE, taken when there is no owner or the owner releases.

Top module: `arb_top`

## Requirements
- R1: While reset is low, and at the first sample after it, the grant vector is zero, busy is low and the arbitration lines are zero.
- R2: Master i has arbitration number N_MASTERS - i (5, 4, 3, 2, 1 by default), so a lower index means a larger number. The contest is won by the candidate with the largest number.
- R3: At most one grant bit is high at any time.
- R4: When no master other than the owner requests, no contest starts. The machine stays in IDLE and no new grant appears.
- R5: The machine is in IDLE, there is no owner, and a request is seen at a clock edge. The grant appears NUM_W + 2 edges later: one edge to start, NUM_W settle edges, and one handover edge.
- R6: During a contest the lines carry the OR of the numbers of the slices still competing. A slice leaves when its bit is 0 and the line bit is 1. In HOLD the lines equal the winner's number. In IDLE they are zero.
- R7: An owner keeps its grant, unchanged, until it pulses tenure_rel. A pending winner waits in HOLD until then, and at the release edge the grant moves directly from the owner to the winner.
- R8: Candidates are sampled at the start edge as the requests of all non-owners. The owner's request is ignored, and a request raised after the start waits for the next contest.
- R9: A tenure_rel pulse with no owner has no effect. A pulse during IDLE or SETTLE clears the grant, and busy falls.
- R10: busy is high exactly when some grant bit is high, and it rises only through a handover from HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_MASTERS | Bus request, one bit per master |
| tenure_rel | input | 1 | Pulse from the current owner that gives up tenure |
| grant | output | N_MASTERS | One-hot tenure grant |
| bus_busy | output | 1 | High while some master holds tenure |
| arb_lines | output | NUM_W | Resolved value of the shared arbitration lines |

## Verification
The assertions need two things from the inputs. The master count must fit the number width, N_MASTERS <= 2^NUM_W - 1, so that every number is distinct and nonzero. Reset must be held for at least one edge. They place no limit on when requests or release pulses occur. The stimulus therefore mixes directed contests with a free-running phase in which masters raise requests at any cycle and drop them once granted. In that phase, release pulses arrive only from an active owner. The directed part adds stray release pulses and requests that arrive after a contest has started.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_SETTLE = 2'd1,
        ARB_HOLD   = 2'd2
    } arb_state_e;

    // Fixed arbitration number of slice idx: lower index, larger number
    function automatic int arb_number(input int idx, input int masters);
        return masters - idx;
    endfunction

endpackage

// File: rtl/arb_slice.sv
`timescale 1ns/1ps
module arb_slice #(
    parameter int NUM_W     = 3,
    parameter int MY_NUM    = 1,
    parameter int BIT_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 enter,
    input  logic                 step_en,
    input  logic                 clear,
    input  logic [BIT_IDX_W-1:0] bit_sel,
    input  logic [NUM_W-1:0]     lines,
    output logic                 alive,
    output logic [NUM_W-1:0]     drive
);
    localparam logic [NUM_W-1:0] MY_CODE = NUM_W'(MY_NUM);

    logic alive_q;
    logic lose;

    // Loses this bit when the lines show 1 and the own bit is 0
    always_comb lose = lines[bit_sel] & ~MY_CODE[bit_sel];

    always_ff @(posedge clk) begin
        if (!rst_n)                alive_q <= 1'b0;
        else if (clear)            alive_q <= 1'b0;
        else if (load)             alive_q <= enter;
        else if (step_en && lose)  alive_q <= 1'b0;
    end

    assign alive = alive_q;
    assign drive = alive_q ? MY_CODE : '0;

endmodule

// File: rtl/arb_wor.sv
`timescale 1ns/1ps
module arb_wor #(
    parameter int N_MASTERS = 5,
    parameter int NUM_W     = 3
) (
    input  logic [N_MASTERS-1:0][NUM_W-1:0] drv,
    output logic [NUM_W-1:0]                lines
);
    always_comb begin
        lines = '0;
        for (int i = 0; i < N_MASTERS; i++) lines = lines | drv[i];
    end
endmodule

// File: rtl/arb_fsm.sv
`timescale 1ns/1ps
module arb_fsm
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 5,
    parameter int NUM_W     = 3,
    parameter int BIT_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] cand,
    input  logic [N_MASTERS-1:0] alive,
    input  logic                 tenure_rel,
    output logic                 load,
    output logic                 step_en,
    output logic                 clear,
    output logic [BIT_IDX_W-1:0] bit_sel,
    output logic [N_MASTERS-1:0] grant,
    output arb_state_e           state
);
    localparam logic [BIT_IDX_W-1:0] LAST = BIT_IDX_W'(NUM_W - 1);

    arb_state_e             state_q, state_d;
    logic [BIT_IDX_W-1:0]   cnt_q;
    logic [N_MASTERS-1:0]   grant_q;
    logic                   handover;

    // State register, step counter, tenure grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            cnt_q   <= '0;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (load)         cnt_q <= '0;
            else if (step_en) cnt_q <= cnt_q + 1'b1;
            if (handover)        grant_q <= alive;
            else if (tenure_rel) grant_q <= '0;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        step_en  = 1'b0;
        clear    = 1'b0;
        handover = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (|cand) begin
                    load    = 1'b1;
                    state_d = ARB_SETTLE;
                end
            end
            ARB_SETTLE: begin
                step_en = 1'b1;
                if (cnt_q == LAST) state_d = ARB_HOLD;
            end
            ARB_HOLD: begin
                if (grant_q == '0 || tenure_rel) begin
                    handover = 1'b1;
                    clear    = 1'b1;
                    state_d  = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    assign bit_sel = LAST - cnt_q;
    assign grant   = grant_q;
    assign state   = state_q;

endmodule

// File: rtl/arb_top.sv
`timescale 1ns/1ps
module arb_top
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 5,
    parameter int NUM_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 tenure_rel,
    output logic [N_MASTERS-1:0] grant,
    output logic                 bus_busy,
    output logic [NUM_W-1:0]     arb_lines
);
    localparam int BIT_IDX_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

    logic [N_MASTERS-1:0]            cand;
    logic [N_MASTERS-1:0]            alive;
    logic [N_MASTERS-1:0][NUM_W-1:0] drv;
    logic                            load, step_en, clear;
    logic [BIT_IDX_W-1:0]            bit_sel;
    arb_state_e                      state;

    assign cand = req & ~grant;

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_slice
        arb_slice #(
            .NUM_W    (NUM_W),
            .MY_NUM   (arb_number(g, N_MASTERS)),
            .BIT_IDX_W(BIT_IDX_W)
        ) slice_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .enter  (cand[g]),
            .step_en(step_en),
            .clear  (clear),
            .bit_sel(bit_sel),
            .lines  (arb_lines),
            .alive  (alive[g]),
            .drive  (drv[g])
        );
    end

    arb_wor #(.N_MASTERS(N_MASTERS), .NUM_W(NUM_W)) wor_i (
        .drv  (drv),
        .lines(arb_lines)
    );

    arb_fsm #(.N_MASTERS(N_MASTERS), .NUM_W(NUM_W), .BIT_IDX_W(BIT_IDX_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand      (cand),
        .alive     (alive),
        .tenure_rel(tenure_rel),
        .load      (load),
        .step_en   (step_en),
        .clear     (clear),
        .bit_sel   (bit_sel),
        .grant     (grant),
        .state     (state)
    );

    assign bus_busy = |grant;

endmodule

// File: rtl/arb_chk.sv
`timescale 1ns/1ps
module arb_chk
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 5,
    parameter int NUM_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req,
    input logic                 tenure_rel,
    input logic [N_MASTERS-1:0] grant,
    input logic                 bus_busy,
    input logic [NUM_W-1:0]     arb_lines,
    input logic [N_MASTERS-1:0] alive,
    input arb_state_e           state
);
    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(state) == ARB_HOLD);

    // R7
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !tenure_rel) |=> $stable(grant));

    // R6
    winner_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_HOLD) |-> ($onehot(alive) && arb_lines != '0));

    // R6
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE) |-> arb_lines == '0);

    // R4
    no_contest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && (req & ~grant) == '0) |=> state == ARB_IDLE);

    // R9
    stray_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && state != ARB_HOLD) |=> !bus_busy);

endmodule

bind arb_top arb_chk #(.N_MASTERS(N_MASTERS), .NUM_W(NUM_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .tenure_rel(tenure_rel),
    .grant     (grant),
    .bus_busy  (bus_busy),
    .arb_lines (arb_lines),
    .alive     (alive),
    .state     (state)
);

// File: tb/arb_top_tb_top.sv
`timescale 1ns/1ps
module arb_top_tb_top;
    localparam int N = 5;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         rel = 1'b0;
    logic [N-1:0] grant;
    logic         busy;
    logic [W-1:0] lines;

    always #2 clk = ~clk;

    arb_top #(.N_MASTERS(N), .NUM_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .tenure_rel(rel),
        .grant(grant), .bus_busy(busy), .arb_lines(lines)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit in_rst = 1'b1;

    // Behavioural model: 0 idle, 1 settle, 2 hold
    int m_state = 0;
    int m_cnt   = 0;
    int m_owner = -1;
    int m_win   = -1;

    function automatic logic [N-1:0] own_vec();
        logic [N-1:0] v;
        v = '0;
        if (m_owner >= 0) v[m_owner] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [N-1:0] cand;
        int best;
        cand = req & ~own_vec();
        case (m_state)
            0: begin
                if (rel) m_owner = -1;
                if (cand != '0) begin
                    best = 0;
                    for (int i = 0; i < N; i++)
                        if (cand[i] && (N - i) > best) begin best = N - i; m_win = i; end
                    m_state = 1;
                    m_cnt   = 0;
                end
            end
            1: begin
                if (rel) m_owner = -1;
                m_cnt++;
                if (m_cnt == W) m_state = 2;
            end
            default: begin
                if (m_owner < 0 || rel) begin
                    m_owner = m_win;
                    m_state = 0;
                end
            end
        endcase
    endtask

    task automatic compare();
        check("R2 R3 R7 grant", longint'(grant), longint'(own_vec()));
        check("R10 busy", longint'(busy), longint'(m_owner >= 0));
        if (m_state == 0) check("R6 idle lines", longint'(lines), 0);
        if (m_state == 2) check("R6 winner lines", longint'(lines), longint'(N - m_win));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!in_rst) begin
            model_step();
            compare();
        end
    endtask

    task automatic pulse_rel();
        rel = 1'b1;
        tick();
        rel = 1'b0;
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset grant", longint'(grant), 0);
        check("R1 reset busy", longint'(busy), 0);
        check("R1 reset lines", longint'(lines), 0);
        rst_n  = 1'b1;
        in_rst = 1'b0;

        // R4: no requests, nothing happens
        repeat (8) tick();
        check("R4 no request no grant", longint'(grant), 0);

        // R5: latency from request to grant
        req[0] = 1'b1;
        lat = 0;
        do begin tick(); lat++; end while (grant == '0 && lat < 20);
        check("R5 grant latency", lat, W + 2);

        // R7 / R8: owner 0 keeps requesting; masters 1,3,4 contest
        req[1] = 1'b1; req[3] = 1'b1; req[4] = 1'b1;
        repeat (W + 3) tick();
        check("R7 owner keeps grant", longint'(grant), 1);
        pulse_rel();
        check("R8 owner request ignored, R2 number 4 wins", longint'(grant), 2);
        req[0] = 1'b0; req[1] = 1'b0;

        // R8: late request waits for next contest
        tick();
        req[0] = 1'b1;
        repeat (W + 2) tick();
        check("R6 lines show winner 2", longint'(lines), 2);
        pulse_rel();
        check("R8 late request waits", longint'(grant), 8);
        req[3] = 1'b0;
        repeat (W + 3) tick();
        pulse_rel();
        check("R2 number 5 wins", longint'(grant), 1);
        req[0] = 1'b0;
        repeat (W + 3) tick();
        pulse_rel();
        check("R2 last requester", longint'(grant), 16);
        req[4] = 1'b0;
        pulse_rel();
        check("R9 release clears grant", longint'(busy), 0);

        // R9: stray release with no owner
        repeat (3) tick();
        pulse_rel();
        tick();
        check("R9 stray release no effect", longint'(grant), 0);

        // R9: release during SETTLE drops busy, winner then taken at once
        req[2] = 1'b1;
        repeat (W + 2) tick();
        req[2] = 1'b0;
        req[1] = 1'b1;
        tick();
        tick();
        pulse_rel();
        check("R9 release in settle", longint'(busy), 0);
        repeat (W + 2) tick();
        check("R9 winner after gap", longint'(grant), 2);
        req = '0;
        pulse_rel();

        // Free-running mix
        for (int c = 0; c < 600; c++) begin
            for (int i = 0; i < N; i++) begin
                if (grant[i]) req[i] = 1'b0;
                else if (!req[i] && ($urandom % 5) == 0) req[i] = 1'b1;
            end
            rel = busy && (($urandom % 6) == 0);
            tick();
        end
        rel = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule